// File: doc/BRIEF.md
# Byte-Wide EEPROM Page-Write Sequencer

This block models the control logic of a byte-alterable nonvolatile memory organised as bytes behind a parallel strobe interface. Three active-low strobes (chip enable, output enable, write enable) are sampled in a system clock domain. The block decodes them into array reads and byte loads. Byte loads are gathered into a page buffer, and after a quiet interval the buffer is committed to a register array by a timed internal programming phase.

A load sequence opens with its first accepted byte. That byte fixes the page, which is the address bits above the in-page offset. Later loads join the sequence only if they carry the same page bits. A load window restarts at the start of every write cycle. Once the window runs out with no write in progress, programming begins. Programming lasts a fixed number of clock cycles. During programming, reads return polling status instead of array data: bit 7 is the complement of bit 7 of the last accepted byte, and bit 6 inverts on every read. The load window and the programming time are parameters in clock cycles, so a short bench can scale them down.

The strobes are plain level pins rather than a valid/ready stream. The block applies no back-pressure. A host learns that the block is busy only through the polling bits, and any write it issues while programming runs is dropped.

Top module: `eep_page_writer`

## Requirements
- R1: When ce_n and oe_n are both sampled low on a clock edge, dout_en is high after that edge and dout holds the array byte at the sampled address; otherwise dout_en is low and dout is zero after the edge (one cycle of read latency).
- R2: A write cycle is the interval in which ce_n and we_n are both low while oe_n is high. The address is captured at the edge where this condition first holds, which is the later of the two falling strobes. The data is captured at the edge where the condition first stops holding, which is the earlier rising strobe. With oe_n low, nothing is written.
- R3: The first write cycle accepted while idle opens a load sequence and records its page, which is address bits ADDR_W-1 down to PAGE_W. Every later load with the same page is stored at the offset given by bits PAGE_W-1:0. There can be from 1 up to 2^PAGE_W loads, and a repeated offset keeps the newest data.
- R4: A load whose page differs from the page of the open sequence is dropped. It does not alter the buffer, the array or the polling byte.
- R5: Programming begins at the first edge where, with no write cycle in progress, WIN_CYC cycles have passed since the latest write-cycle start. Each new start restarts that count, so a sequence of any length stays open, and reads during loading return array data.
- R6: Programming lasts PROG_CYC cycles. Write cycles that start during programming are ignored. Afterwards the loaded bytes read back, and the bytes of the page that were not loaded keep their earlier contents.
- R7: During programming, every read returns bit 7 equal to the complement of bit 7 of the last accepted byte, and bits 5:0 equal to zero, for any address.
- R8: During programming, bit 6 of read data inverts at each new read start. The first read after programming begins shows 1, and the value holds for the rest of that read.
- R9: After reset the array holds 8'hFF in every byte, the block is idle and dout_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| addr | input | ADDR_W | Byte address; the top ADDR_W-PAGE_W bits select the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | High while the block drives the data bus |

## Verification
The bench builds the block with ADDR_W=8, PAGE_W=4, WIN_CYC=24 and PROG_CYC=40, which gives 16-byte pages and 16 pages. With these values a whole page fill, a sequence that outlives several windows, an off-page load and a write attempted during programming all fit in a few hundred cycles. The short programming phase leaves room for several polling reads in one phase and for read-back straight after it ends. The reference model follows every clock, so the exact edge of window expiry and of programming completion is checked, not just the final array contents.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } eep_phase_t;
endpackage

// File: rtl/eep_strobe_sync.sv
// Turns sampled strobes into write-cycle and read-cycle edge events.
module eep_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_start,
  output logic wr_end,
  output logic wr_hold,
  output logic rd_now,
  output logic rd_start
);
  logic wr_now, wr_q, rd_q;

  assign wr_now = ~ce_n & ~we_n & oe_n;
  assign rd_now = ~ce_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_now;
      rd_q <= rd_now;
    end
  end

  assign wr_start = wr_now & ~wr_q;  // later of the two falling strobes
  assign wr_end   = ~wr_now & wr_q;  // earlier of the two rising strobes
  assign wr_hold  = wr_q;
  assign rd_start = rd_now & ~rd_q;
endmodule

// File: rtl/eep_timers.sv
// Load-window counter (restartable, saturating) and programming counter.
module eep_timers #(
  parameter int WIN_CYC  = 2500,
  parameter int PROG_CYC = 125000,
  localparam int WW = $clog2(WIN_CYC + 1),
  localparam int PW = $clog2(PROG_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_restart,
  input  logic          prog_begin,
  input  logic          prog_run,
  output logic          win_expired,
  output logic [PW-1:0] prog_cnt,
  output logic          prog_last
);
  localparam logic [WW-1:0] WIN_MAX  = WW'(WIN_CYC);
  localparam logic [PW-1:0] PROG_END = PW'(PROG_CYC - 1);

  logic [WW-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= WIN_MAX;
    end else if (win_restart) begin
      win_cnt <= '0;
    end else if (win_cnt != WIN_MAX) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_cnt <= '0;
    end else if (prog_begin) begin
      prog_cnt <= '0;
    end else if (prog_run) begin
      prog_cnt <= prog_cnt + 1'b1;
    end
  end

  assign win_expired = (win_cnt == WIN_MAX);
  assign prog_last   = (prog_cnt == PROG_END);
endmodule

// File: rtl/eep_page_buffer.sv
// Page staging buffer with a per-byte loaded flag.
module eep_page_buffer #(
  parameter int PAGE_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PAGE_W-1:0]     wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  clear,
  input  logic [PAGE_W-1:0]     rd_idx,
  output logic [7:0]            rd_data,
  output logic                  rd_loaded,
  output logic [PAGE_BYTES-1:0] loaded_mask
);
  logic [7:0] slot [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g]        <= 8'h00;
        loaded_mask[g] <= 1'b0;
      end else if (clear) begin
        loaded_mask[g] <= 1'b0;
      end else if (wr_en && (wr_idx == PAGE_W'(g))) begin
        slot[g]        <= wr_data;
        loaded_mask[g] <= 1'b1;
      end
    end
  end

  assign rd_data   = slot[rd_idx];
  assign rd_loaded = loaded_mask[rd_idx];
endmodule

// File: rtl/eep_page_writer.sv
// Top: phase control, register array, read/polling output.
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 8,
  parameter int WIN_CYC  = 2500,
  parameter int PROG_CYC = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int PW         = $clog2(PROG_CYC + 1);

  eep_phase_t phase;
  logic wr_start, wr_end, wr_hold, rd_now, rd_start;
  logic win_expired, prog_last;
  logic [PW-1:0] prog_cnt;
  logic [ADDR_W-1:0] addr_lat;
  logic armed;
  logic [PG_W-1:0] page_q;
  logic [7:0] last_byte;
  logic tog_q;
  logic [7:0] buf_rd;
  logic buf_loaded;
  logic [PAGE_BYTES-1:0] loaded_mask;
  logic [7:0] mem [DEPTH];

  logic commit, accept, go_prog, prog_done, prog_wr, win_restart;
  logic [PAGE_W-1:0] prog_idx;
  logic [7:0] status;

  eep_strobe_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_start(wr_start), .wr_end(wr_end), .wr_hold(wr_hold),
    .rd_now(rd_now), .rd_start(rd_start)
  );

  assign win_restart = wr_start && (phase != PH_PROG);
  assign go_prog     = (phase == PH_LOAD) && win_expired && !wr_hold && !wr_start;
  assign prog_done   = (phase == PH_PROG) && prog_last;

  eep_timers #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_timers (
    .clk(clk), .rst_n(rst_n), .win_restart(win_restart),
    .prog_begin(go_prog), .prog_run(phase == PH_PROG),
    .win_expired(win_expired), .prog_cnt(prog_cnt), .prog_last(prog_last)
  );

  assign commit = wr_end && armed;
  assign accept = commit &&
                  ((phase == PH_IDLE) ||
                   ((phase == PH_LOAD) && (addr_lat[ADDR_W-1:PAGE_W] == page_q)));

  assign prog_idx = prog_cnt[PAGE_W-1:0];
  assign prog_wr  = (phase == PH_PROG) && (32'(prog_cnt) < PAGE_BYTES) && buf_loaded;

  eep_page_buffer #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_idx(addr_lat[PAGE_W-1:0]), .wr_data(din),
    .clear(prog_done), .rd_idx(prog_idx),
    .rd_data(buf_rd), .rd_loaded(buf_loaded), .loaded_mask(loaded_mask)
  );

  // Phase, capture and sequence state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      addr_lat  <= '0;
      armed     <= 1'b0;
      page_q    <= '0;
      last_byte <= 8'h00;
    end else begin
      if (win_restart) begin
        addr_lat <= addr;
        armed    <= 1'b1;
      end else if (wr_end || go_prog) begin
        armed <= 1'b0;
      end
      if (accept) begin
        last_byte <= din;
        if (phase == PH_IDLE) begin
          page_q <= addr_lat[ADDR_W-1:PAGE_W];
          phase  <= PH_LOAD;
        end
      end
      if (go_prog) begin
        phase <= PH_PROG;
      end else if (prog_done) begin
        phase <= PH_IDLE;
      end
    end
  end

  // Register array, swept one page slot per cycle during programming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_wr) begin
      mem[{page_q, prog_idx}] <= buf_rd;
    end
  end

  // Read path and polling status
  always_comb begin
    status    = 8'h00;
    status[7] = ~last_byte[7];
    status[6] = rd_start ? ~tog_q : tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      dout    <= 8'h00;
      dout_en <= 1'b0;
    end else begin
      if (go_prog) begin
        tog_q <= 1'b0;
      end else if ((phase == PH_PROG) && rd_start) begin
        tog_q <= ~tog_q;
      end
      dout_en <= rd_now;
      if (!rd_now) begin
        dout <= 8'h00;
      end else if (phase == PH_PROG) begin
        dout <= status;
      end else begin
        dout <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
  import eep_pkg::*;
#(
  parameter int PAGE_BYTES = 256
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ce_n,
  input logic                  oe_n,
  input logic [7:0]            dout,
  input logic                  dout_en,
  input eep_phase_t            phase,
  input logic [7:0]            last_byte,
  input logic [PAGE_BYTES-1:0] loaded_mask,
  input logic                  wr_hold
);
  // R1: read strobes drive the bus one cycle later
  p_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |=> dout_en);

  // R1: bus released and zero when not reading
  p_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> (!dout_en && dout == 8'h00));

  // R5: window cannot expire while a write cycle is in progress
  p_hold_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && wr_hold) |=> (phase != PH_PROG));

  // R6: buffer contents frozen while programming runs
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROG) |=> (phase != PH_PROG || $stable(loaded_mask)));

  // R7: polling bit 7 complements last accepted byte, low bits zero
  p_poll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PROG && !ce_n && !oe_n) |=>
      (dout[7] == ~$past(last_byte[7]) && dout[5:0] == 6'd0));
endmodule

bind eep_page_writer eep_page_writer_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .dout(dout), .dout_en(dout_en), .phase(phase),
  .last_byte(last_byte), .loaded_mask(loaded_mask), .wr_hold(wr_hold)
);

// File: tb/eep_page_writer_bench.sv
`timescale 1ns/1ps
module eep_page_writer_bench;
  localparam int AW   = 8;
  localparam int PGW  = 4;
  localparam int PB   = 1 << PGW;
  localparam int WIN  = 24;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  eep_page_writer #(.ADDR_W(AW), .PAGE_W(PGW), .WIN_CYC(WIN), .PROG_CYC(PROG))
    u_eep_page_writer (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

  // ---------------- behavioural reference model ----------------
  int m_st;          // 0 idle, 1 loading, 2 programming
  bit m_wrq, m_rdq, m_armed, m_tog;
  int m_alat, m_win, m_prog, m_page;
  int m_mem [1 << AW];
  int m_buf [PB];
  bit m_mask [PB];
  logic [7:0] m_last;
  logic [7:0] exp_d;
  bit exp_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wrq = 0; m_rdq = 0; m_armed = 0; m_tog = 0;
      m_alat = 0; m_win = WIN; m_prog = 0; m_page = 0; m_last = 0;
      for (int i = 0; i < (1 << AW); i++) m_mem[i] = 8'hFF;
      for (int i = 0; i < PB; i++) begin m_buf[i] = 0; m_mask[i] = 0; end
      exp_d = 0; exp_en = 0;
    end else begin
      bit wr, rd, st_ev, fin, rs, go, done, com;
      int st0;
      logic b6;
      st0 = m_st;
      wr = !ce_n && !we_n && oe_n;
      rd = !ce_n && !oe_n;
      st_ev = wr && !m_wrq;
      fin = !wr && m_wrq;
      rs = rd && !m_rdq;
      exp_en = rd;
      if (!rd) exp_d = 0;
      else if (st0 == 2) begin
        b6 = rs ? !m_tog : m_tog;
        exp_d = {~m_last[7], b6, 6'b0};
      end else exp_d = m_mem[addr][7:0];
      if (st0 == 2 && rs) m_tog = !m_tog;
      go = (st0 == 1) && (m_win >= WIN) && !m_wrq && !st_ev;
      done = (st0 == 2) && (m_prog == PROG - 1);
      com = fin && m_armed;
      if (st0 == 2) begin
        if (m_prog < PB && m_mask[m_prog]) m_mem[m_page * PB + m_prog] = m_buf[m_prog];
        m_prog++;
        if (done) begin
          m_st = 0;
          for (int i = 0; i < PB; i++) m_mask[i] = 0;
        end
      end
      if (com) begin
        m_armed = 0;
        if (st0 == 0 || (st0 == 1 && m_alat / PB == m_page)) begin
          if (st0 == 0) begin m_page = m_alat / PB; m_st = 1; end
          m_buf[m_alat % PB] = din;
          m_mask[m_alat % PB] = 1;
          m_last = din;
        end
      end
      if (st_ev && st0 != 2) begin
        m_alat = addr; m_armed = 1; m_win = 0;
      end else if (m_win < WIN) m_win++;
      if (go) begin m_st = 2; m_prog = 0; m_tog = 0; m_armed = 0; end
      m_wrq = wr; m_rdq = rd;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (dout !== exp_d || dout_en !== exp_en) begin
        errors++;
        $display("FAIL %s cycle: dout=%h en=%b expected dout=%h en=%b",
                 tag, dout, dout_en, exp_d, exp_en);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_we(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = a;
    @(negedge clk); we_n = 0;
    @(negedge clk);
    @(negedge clk); din = d; we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic wr_ce(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 0; addr = a;
    @(negedge clk); ce_n = 0;
    @(negedge clk);
    @(negedge clk); din = d; ce_n = 1;
    @(negedge clk); we_n = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk); v = dout;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [7:0] exp, string req);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    tag = "R9";
    check("R9 reset dout_en", {7'd0, dout_en}, 8'h00);
    rst_n = 1;
    idle(2);
    rd_chk(8'h00, 8'hFF, "R9 erased array");
    rd_chk(8'hC7, 8'hFF, "R9 erased array");

    // single byte load, polling, read-back
    tag = "R2";
    wr_we(8'h12, 8'h35);
    idle(WIN + 2);
    tag = "R7";
    rd_chk(8'h00, 8'hC0, "R7/R8 first poll");
    rd_chk(8'h12, 8'h80, "R8 second poll toggles");
    rd_chk(8'h44, 8'hC0, "R8 third poll toggles");
    idle(PROG + 2);
    tag = "R6";
    rd_chk(8'h12, 8'h35, "R6 byte programmed");
    rd_chk(8'h13, 8'hFF, "R6 neighbour untouched");

    // full page load across several windows, mixed strobe orders
    tag = "R3";
    for (int i = 0; i < PB; i++) begin
      if (i[0]) wr_ce(AW'(8'h30 + i), 8'(8'h40 + i));
      else      wr_we(AW'(8'h30 + i), 8'(8'h40 + i));
      if (i == 5) begin
        tag = "R4";
        wr_we(8'h52, 8'h77);
        tag = "R3";
      end
      if (i == 8) begin
        tag = "R5";
        rd_chk(8'h31, 8'hFF, "R5 still loading, array unchanged");
        tag = "R3";
      end
      idle(4);
    end
    idle(WIN + 2);
    tag = "R7";
    rd_chk(8'h52, 8'hC0, "R4/R7 poll uses last accepted byte");
    idle(PROG + 2);
    tag = "R3";
    for (int i = 0; i < PB; i++)
      rd_chk(AW'(8'h30 + i), 8'(8'h40 + i), "R3 page byte");
    rd_chk(8'h52, 8'hFF, "R4 off-page load dropped");

    // partial reload, write during programming, overwrite same offset
    tag = "R6";
    wr_we(8'h32, 8'h11);
    wr_ce(8'h32, 8'hA5);
    wr_we(8'h35, 8'hDA);
    idle(WIN + 2);
    rd_chk(8'h00, 8'h40, "R7 bit7 complement of 1");
    wr_we(8'h70, 8'h11);
    rd_chk(8'h00, 8'h00, "R8 toggle back");
    idle(PROG + 2);
    rd_chk(8'h32, 8'hA5, "R3 newest data at repeated offset");
    rd_chk(8'h35, 8'hDA, "R6 reloaded byte");
    rd_chk(8'h33, 8'h43, "R6 unloaded byte kept");
    rd_chk(8'h70, 8'hFF, "R6 write during programming ignored");

    // oe low blocks a write; ce alone does not drive
    tag = "R2";
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 8'h80; din = 8'h5C;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; oe_n = 1;
    tag = "R1";
    @(negedge clk); ce_n = 0; oe_n = 1; addr = 8'h30;
    @(negedge clk);
    check("R1 no drive with oe_n high", {7'd0, dout_en}, 8'h00);
    ce_n = 1;
    idle(WIN + PROG + 4);
    rd_chk(8'h80, 8'hFF, "R2 oe low write not stored");
    rd(8'h34, v);
    check("R1 read data", v, 8'h44);

    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule